// File: doc/BRIEF.md
# Level-Tracking Interrupt Pending Controller

This block collects up to 96 level-sensitive interrupt lines and drives two request outputs: a normal request (`irq_o`) and a fast request (`fiq_o`). Each source owns one pending bit. Source number n sits in bit (n mod 32) of pending word (n div 32). A per-word route register sends each source either to the normal path or to the fast path. A per-word enable register masks each source before it reaches its output.

By default the pending bits are a registered copy of the source lines. Software cannot clear them. A handler clears a request by quieting the device that raised it. Bus writes to the pending words are dropped. Because of this, a careless acknowledge sequence can never lose a request. With `CLEAR_MODE = 1` the pending bits become sticky instead. A high source sets its bit. The bit then stays set until software writes a 1 to it through the bank the source is routed to.

Software reaches the controller through a simple single-cycle register port. Writes take effect at the clock edge. Read data is combinational from the current state.

Top module: `lpc_level_pend`

## Requirements
- R1: Synchronous reset (`rst_i` high at a clock edge) clears the enable words, the route words, the pending state and both outputs.
- R2: Register address map, with a byte address of which bits [1:0] are ignored. Bits [3:2] give the word index w (0..2). Bits [5:4] give the group: 0 is the normal pending bank, 1 is the fast pending bank, 2 is enable and 3 is route. A normal-bank read of word w returns pending & ~route. A fast-bank read returns pending & route. Source n is bit n%32 of word n/32.
- R3: In the default mode, one edge after the source lines are sampled, every pending bit equals the level its source had at that edge.
- R4: In the default mode, a write to any normal or fast pending word leaves the pending state unchanged.
- R5: With `CLEAR_MODE = 1`, a pending bit stays set after its source falls. It is cleared only by writing 1 to it through the bank that currently shows it. The same write has no effect through the other bank.
- R6: In both modes, a source that is high at an edge has its pending bit set after that edge, even when the same edge carries a clear for that bit.
- R7: Enable and route words are readable and writable. Each one changes only on a write to its own address.
- R8: After every edge, `irq_o` equals the OR of (pending & enable & ~route) and `fiq_o` equals the OR of (pending & enable & route), both taken over the state produced by that same edge.
- R9: A read-modify-write that ORs one bit into the value read back from a pending word behaves as follows. In the default mode it removes no request whose line is still high. With `CLEAR_MODE = 1` it clears every latched bit shown in that read, except bits whose sources are high.
- R10: Word index 3 is unmapped in every group: it reads as zero and writes to it change nothing. Reads never change state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_i | input | 1 | Synchronous active-high reset |
| src_i | input | NUM_SRC | Level interrupt lines, synchronous to clk_i |
| wr_i | input | 1 | Write strobe for the register port |
| addr_i | input | ADDR_W | Byte address (group, word index, two ignored bits) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 1 | Registered normal interrupt request |
| fiq_o | output | 1 | Registered fast interrupt request |

## Verification
The sharp collision is a source line rising or staying high in the same cycle that software writes a clear to its pending word, optionally while the route word for that source is also being rewritten. Random stimulus is used to provoke it. Sparse random source words are driven each cycle, and random writes to every group and index, including the unmapped one, are interleaved with them. Both modes are instantiated side by side on identical stimulus. Each edge is judged against a bench model: it takes the clear mask from the route value that held before the edge, lets a high source beat the clear, and only then applies configuration writes to compute the expected outputs. A directed read-modify-write acknowledge shows that no request is lost in the default mode and that the whole word is wiped in sticky mode.

// File: rtl/lpc_pkg.sv
package lpc_pkg;

  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    GRP_NORM_PEND = 2'd0,
    GRP_FAST_PEND = 2'd1,
    GRP_ENABLE    = 2'd2,
    GRP_ROUTE     = 2'd3
  } grp_e;

  // Bits of a word that one bank exposes: fast bank shows routed bits.
  function automatic logic [WORD_W-1:0] bank_view(input logic [WORD_W-1:0] pend,
                                                  input logic [WORD_W-1:0] route,
                                                  input logic              fast);
    return fast ? (pend & route) : (pend & ~route);
  endfunction

  // True when any enabled source of a word drives the chosen output.
  function automatic logic word_hit(input logic [WORD_W-1:0] pend,
                                    input logic [WORD_W-1:0] en,
                                    input logic [WORD_W-1:0] route,
                                    input logic              fast);
    return |(bank_view(pend, route, fast) & en);
  endfunction

endpackage

// File: rtl/lpc_decode.sv
module lpc_decode
  import lpc_pkg::*;
#(
  parameter int NW    = 3,
  parameter int IDX_W = 2,
  parameter int AW    = 6
) (
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  output grp_e          grp_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [NW-1:0] wen_enable_o,
  output logic [NW-1:0] wen_route_o,
  output logic [NW-1:0] clr_norm_o,
  output logic [NW-1:0] clr_fast_o
);

  assign idx_o = addr_i[2 +: IDX_W];
  assign grp_o = grp_e'(addr_i[2+IDX_W +: 2]);

  for (genvar w = 0; w < NW; w++) begin : g_word
    logic hit;
    assign hit             = wr_i && (int'(idx_o) == w);
    assign wen_enable_o[w] = hit && (grp_o == GRP_ENABLE);
    assign wen_route_o[w]  = hit && (grp_o == GRP_ROUTE);
    assign clr_norm_o[w]   = hit && (grp_o == GRP_NORM_PEND);
    assign clr_fast_o[w]   = hit && (grp_o == GRP_FAST_PEND);
  end

endmodule

// File: rtl/lpc_cfg.sv
module lpc_cfg
  import lpc_pkg::*;
#(
  parameter int NW = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_i,
  input  logic [NW-1:0]        wen_enable_i,
  input  logic [NW-1:0]        wen_route_i,
  input  logic [WORD_W-1:0]    wdata_i,
  output logic [NW*WORD_W-1:0] en_q_o,
  output logic [NW*WORD_W-1:0] route_q_o,
  output logic [NW*WORD_W-1:0] en_d_o,
  output logic [NW*WORD_W-1:0] route_d_o
);

  for (genvar w = 0; w < NW; w++) begin : g_word
    assign en_d_o[w*WORD_W +: WORD_W]    = wen_enable_i[w] ? wdata_i : en_q_o[w*WORD_W +: WORD_W];
    assign route_d_o[w*WORD_W +: WORD_W] = wen_route_i[w]  ? wdata_i : route_q_o[w*WORD_W +: WORD_W];
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      en_q_o    <= '0;
      route_q_o <= '0;
    end else begin
      en_q_o    <= en_d_o;
      route_q_o <= route_d_o;
    end
  end

  a_r7_enable_stable: assert property (@(posedge clk_i) disable iff (rst_i)
    (wen_enable_i == '0) |=> $stable(en_q_o));
  a_r7_route_stable: assert property (@(posedge clk_i) disable iff (rst_i)
    (wen_route_i == '0) |=> $stable(route_q_o));

endmodule

// File: rtl/lpc_pending.sv
module lpc_pending
  import lpc_pkg::*;
#(
  parameter int NW         = 3,
  parameter bit CLEAR_MODE = 1'b0
) (
  input  logic                 clk_i,
  input  logic                 rst_i,
  input  logic [NW*WORD_W-1:0] src_i,
  input  logic [NW-1:0]        clr_norm_i,
  input  logic [NW-1:0]        clr_fast_i,
  input  logic [WORD_W-1:0]    wdata_i,
  input  logic [NW*WORD_W-1:0] route_q_i,
  output logic [NW*WORD_W-1:0] clr_mask_o,
  output logic [NW*WORD_W-1:0] pend_d_o,
  output logic [NW*WORD_W-1:0] pend_q_o
);

  for (genvar w = 0; w < NW; w++) begin : g_word
    logic [WORD_W-1:0] rt;
    assign rt = route_q_i[w*WORD_W +: WORD_W];
    if (CLEAR_MODE) begin : g_sticky
      // A clear only reaches bits the written bank currently shows.
      assign clr_mask_o[w*WORD_W +: WORD_W] =
          (clr_norm_i[w] ? (wdata_i & ~rt) : '0) |
          (clr_fast_i[w] ? (wdata_i &  rt) : '0);
      assign pend_d_o[w*WORD_W +: WORD_W] = src_i[w*WORD_W +: WORD_W] |
          (pend_q_o[w*WORD_W +: WORD_W] & ~clr_mask_o[w*WORD_W +: WORD_W]);
    end else begin : g_level
      assign clr_mask_o[w*WORD_W +: WORD_W] = '0;
      assign pend_d_o[w*WORD_W +: WORD_W]   = src_i[w*WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) pend_q_o <= '0;
    else       pend_q_o <= pend_d_o;
  end

  // R6: a high line always wins over any clear at the same edge
  a_r6_source_sets: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> ((pend_q_o & $past(src_i)) == $past(src_i)));

  if (CLEAR_MODE) begin : g_chk_sticky
    a_r5_latched_holds: assert property (@(posedge clk_i) disable iff (rst_i)
      (clr_mask_o == '0) |=> ((pend_q_o & $past(pend_q_o)) == $past(pend_q_o)));
  end else begin : g_chk_level
    a_r3_tracks_lines: assert property (@(posedge clk_i) disable iff (rst_i)
      !$past(rst_i) |-> (pend_q_o == $past(src_i)));
    a_r4_no_sw_clear: assert property (@(posedge clk_i) disable iff (rst_i)
      (clr_norm_i != '0 || clr_fast_i != '0) |=> (pend_q_o == $past(src_i)));
  end

endmodule

// File: rtl/lpc_route.sv
module lpc_route
  import lpc_pkg::*;
#(
  parameter int NW = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_i,
  input  logic [NW*WORD_W-1:0] pend_d_i,
  input  logic [NW*WORD_W-1:0] en_d_i,
  input  logic [NW*WORD_W-1:0] route_d_i,
  output logic                 irq_o,
  output logic                 fiq_o
);

  logic [NW-1:0] norm_hit, fast_hit;

  for (genvar w = 0; w < NW; w++) begin : g_word
    assign norm_hit[w] = word_hit(pend_d_i[w*WORD_W +: WORD_W], en_d_i[w*WORD_W +: WORD_W],
                                  route_d_i[w*WORD_W +: WORD_W], 1'b0);
    assign fast_hit[w] = word_hit(pend_d_i[w*WORD_W +: WORD_W], en_d_i[w*WORD_W +: WORD_W],
                                  route_d_i[w*WORD_W +: WORD_W], 1'b1);
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      irq_o <= 1'b0;
      fiq_o <= 1'b0;
    end else begin
      irq_o <= |norm_hit;
      fiq_o <= |fast_hit;
    end
  end

endmodule

// File: rtl/lpc_level_pend.sv
module lpc_level_pend
  import lpc_pkg::*;
#(
  parameter int NUM_SRC    = 96,
  parameter bit CLEAR_MODE = 1'b0,
  localparam int NW        = (NUM_SRC + WORD_W - 1) / WORD_W,
  localparam int IDX_W     = (NW > 2) ? $clog2(NW) : 1,
  localparam int ADDR_W    = 4 + IDX_W
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               wr_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [WORD_W-1:0]  wdata_i,
  output logic [WORD_W-1:0]  rdata_o,
  output logic               irq_o,
  output logic               fiq_o
);

  localparam int FLAT_W = NW * WORD_W;

  grp_e              grp;
  logic [IDX_W-1:0]  idx;
  logic [NW-1:0]     wen_enable, wen_route, clr_norm, clr_fast;
  logic [FLAT_W-1:0] src_flat, clr_mask;
  logic [FLAT_W-1:0] en_q, route_q, en_d, route_d, pend_d, pend_q;

  assign src_flat = FLAT_W'(src_i);

  lpc_decode #(.NW(NW), .IDX_W(IDX_W), .AW(ADDR_W)) u_decode (
    .wr_i(wr_i), .addr_i(addr_i), .grp_o(grp), .idx_o(idx),
    .wen_enable_o(wen_enable), .wen_route_o(wen_route),
    .clr_norm_o(clr_norm), .clr_fast_o(clr_fast)
  );

  lpc_cfg #(.NW(NW)) u_cfg (
    .clk_i(clk_i), .rst_i(rst_i), .wen_enable_i(wen_enable), .wen_route_i(wen_route),
    .wdata_i(wdata_i), .en_q_o(en_q), .route_q_o(route_q), .en_d_o(en_d), .route_d_o(route_d)
  );

  lpc_pending #(.NW(NW), .CLEAR_MODE(CLEAR_MODE)) u_pending (
    .clk_i(clk_i), .rst_i(rst_i), .src_i(src_flat), .clr_norm_i(clr_norm),
    .clr_fast_i(clr_fast), .wdata_i(wdata_i), .route_q_i(route_q),
    .clr_mask_o(clr_mask), .pend_d_o(pend_d), .pend_q_o(pend_q)
  );

  lpc_route #(.NW(NW)) u_route (
    .clk_i(clk_i), .rst_i(rst_i), .pend_d_i(pend_d), .en_d_i(en_d),
    .route_d_i(route_d), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  // Read mux: unmapped index yields zero
  always_comb begin
    rdata_o = '0;
    for (int w = 0; w < NW; w++) begin
      if (int'(idx) == w) begin
        unique case (grp)
          GRP_NORM_PEND: rdata_o = bank_view(pend_q[w*WORD_W +: WORD_W], route_q[w*WORD_W +: WORD_W], 1'b0);
          GRP_FAST_PEND: rdata_o = bank_view(pend_q[w*WORD_W +: WORD_W], route_q[w*WORD_W +: WORD_W], 1'b1);
          GRP_ENABLE:    rdata_o = en_q[w*WORD_W +: WORD_W];
          GRP_ROUTE:     rdata_o = route_q[w*WORD_W +: WORD_W];
          default:       rdata_o = '0;
        endcase
      end
    end
  end

  a_r1_outputs_quiet: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(rst_i) |-> (!irq_o && !fiq_o && pend_q == '0 && en_q == '0));
  a_r8_irq_matches: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(rst_i) |-> (irq_o == |(pend_q & en_q & ~route_q)));
  a_r8_fiq_matches: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(rst_i) |-> (fiq_o == |(pend_q & en_q & route_q)));
  a_r10_no_write_when_idle: assert property (@(posedge clk_i) disable iff (rst_i)
    !wr_i |-> (clr_mask == '0 && wen_enable == '0 && wen_route == '0));

endmodule

// File: tb/tb_lpc_level_pend.sv
module tb_lpc_level_pend;
  localparam int NS = 96;
  localparam int NW = 3;
  localparam int AW = 6;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst;
  logic [NS-1:0] src;
  logic          wr;
  logic [AW-1:0] addr;
  logic [31:0]   wdata;
  logic [31:0]   rd_lvl, rd_stk;
  logic          irq_lvl, fiq_lvl, irq_stk, fiq_stk;

  lpc_level_pend #(.NUM_SRC(NS), .CLEAR_MODE(1'b0)) dut (
    .clk_i(clk), .rst_i(rst), .src_i(src), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rd_lvl), .irq_o(irq_lvl), .fiq_o(fiq_lvl));
  lpc_level_pend #(.NUM_SRC(NS), .CLEAR_MODE(1'b1)) dut_sticky (
    .clk_i(clk), .rst_i(rst), .src_i(src), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rd_stk), .irq_o(irq_stk), .fiq_o(fiq_stk));

  int n_cmp = 0;
  int n_bad = 0;
  logic done = 1'b0;

  logic [31:0] mp [2][NW];
  logic [31:0] me [NW];
  logic [31:0] ms [NW];

  function automatic logic [AW-1:0] ad(input int g, input int i);
    return {g[1:0], i[1:0], 2'b00};
  endfunction

  function automatic logic [31:0] mread(input int m, input logic [AW-1:0] a);
    int g = int'(a[5:4]);
    int i = int'(a[3:2]);
    if (i >= NW) return 32'h0;
    case (g)
      0: return mp[m][i] & ~ms[i];
      1: return mp[m][i] & ms[i];
      2: return me[i];
      default: return ms[i];
    endcase
  endfunction

  function automatic logic mout(input int m, input logic fast);
    logic r = 1'b0;
    for (int w = 0; w < NW; w++)
      r = r | (|(mp[m][w] & me[w] & (fast ? ms[w] : ~ms[w])));
    return r;
  endfunction

  task automatic mupdate(input logic [NS-1:0] s, input logic w, input logic [AW-1:0] a,
                         input logic [31:0] d);
    int g = int'(a[5:4]);
    int i = int'(a[3:2]);
    for (int k = 0; k < NW; k++) begin
      logic [31:0] clr = 32'h0;
      if (w && i == k && g == 0) clr = d & ~ms[k];
      if (w && i == k && g == 1) clr = d & ms[k];
      mp[0][k] = s[k*32 +: 32];
      mp[1][k] = s[k*32 +: 32] | (mp[1][k] & ~clr);
    end
    if (w && i < NW && g == 2) me[i] = d;
    if (w && i < NW && g == 3) ms[i] = d;
  endtask

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Called at a negedge: drive, check reads pre-edge, clock, check outputs.
  task automatic step(input string tag, input logic [NS-1:0] s, input logic w,
                      input logic [AW-1:0] a, input logic [31:0] d);
    src = s; wr = w; addr = a; wdata = d;
    #1;
    if (!w) begin
      chk(tag, "rdata level", rd_lvl, mread(0, a));
      chk(tag, "rdata sticky", rd_stk, mread(1, a));
    end
    @(posedge clk);
    mupdate(s, w, a, d);
    @(negedge clk);
    chk(tag, "irq level", {31'h0, irq_lvl}, {31'h0, mout(0, 1'b0)});
    chk(tag, "fiq level", {31'h0, fiq_lvl}, {31'h0, mout(0, 1'b1)});
    chk(tag, "irq sticky", {31'h0, irq_stk}, {31'h0, mout(1, 1'b0)});
    chk(tag, "fiq sticky", {31'h0, fiq_stk}, {31'h0, mout(1, 1'b1)});
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [NS-1:0] s;
    void'($urandom(32'd20240611));
    for (int m = 0; m < 2; m++) for (int k = 0; k < NW; k++) mp[m][k] = '0;
    for (int k = 0; k < NW; k++) begin me[k] = '0; ms[k] = '0; end
    rst = 1'b1; src = '0; wr = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1", "irq after reset", {31'h0, irq_lvl | irq_stk}, 32'h0);
    chk("R1", "fiq after reset", {31'h0, fiq_lvl | fiq_stk}, 32'h0);
    for (int k = 0; k < 4; k++) step("R1", '0, 1'b0, ad(2, k), '0);

    // R7: enable everything, then read back
    for (int k = 0; k < NW; k++) step("R7", '0, 1'b1, ad(2, k), 32'hFFFF_FFFF);
    for (int k = 0; k < NW; k++) step("R7", '0, 1'b0, ad(2, k), '0);

    // R2/R3: sources 0, 31, 32, 95 land at bit n%32 of word n/32
    s = '0; s[0] = 1'b1; s[31] = 1'b1; s[32] = 1'b1; s[95] = 1'b1;
    step("R3", s, 1'b0, ad(0, 0), '0);
    for (int k = 0; k < NW; k++) step("R2", s, 1'b0, ad(0, k), '0);
    addr = ad(0, 2); #1;
    chk("R2", "source 95 in normal word 2", rd_lvl, 32'h8000_0000);
    @(negedge clk);

    // R7/R8: route source 95 to the fast path
    step("R7", s, 1'b1, ad(3, 2), 32'h8000_0000);
    step("R8", s, 1'b0, ad(1, 2), '0);
    step("R2", s, 1'b0, ad(0, 2), '0);

    // R4/R6: clear attempt while the lines stay high
    step("R4", s, 1'b1, ad(0, 0), 32'hFFFF_FFFF);
    step("R4", s, 1'b0, ad(0, 0), '0);
    addr = ad(0, 0); #1;
    chk("R4", "level word0 after write", rd_lvl, 32'h8000_0001);
    chk("R6", "sticky word0 set wins", rd_stk, 32'h8000_0001);
    @(negedge clk);

    // R5: lines fall; sticky holds until a matching-bank clear
    step("R5", '0, 1'b0, ad(0, 0), '0);
    step("R5", '0, 1'b1, ad(1, 0), 32'h0000_0001);
    step("R5", '0, 1'b0, ad(0, 0), '0);
    step("R5", '0, 1'b1, ad(0, 0), 32'h0000_0001);
    step("R5", '0, 1'b0, ad(0, 0), '0);
    addr = ad(0, 0); #1;
    chk("R5", "sticky word0 after clear", rd_stk, 32'h8000_0000);
    chk("R3", "level word0 after fall", rd_lvl, 32'h0);
    @(negedge clk);

    // R9: acknowledge by read-modify-write
    s = '0; s[3] = 1'b1; s[7] = 1'b1; s[9] = 1'b1;
    step("R9", s, 1'b0, ad(0, 0), '0);
    s = '0; s[7] = 1'b1;
    step("R9", s, 1'b0, ad(0, 0), '0);
    addr = ad(0, 0); #1;
    chk("R9", "sticky word0 before ack", rd_stk, 32'h8000_0288);
    @(negedge clk);
    step("R9", s, 1'b1, ad(0, 0), rd_stk | 32'h8);
    step("R9", s, 1'b0, ad(0, 0), '0);
    addr = ad(0, 0); #1;
    chk("R9", "level keeps live line", rd_lvl, 32'h0000_0080);
    chk("R9", "sticky wiped to live line", rd_stk, 32'h0000_0080);
    @(negedge clk);

    // R10: unmapped index
    for (int g = 0; g < 4; g++) step("R10", s, 1'b1, ad(g, 3), 32'hDEAD_BEEF);
    for (int g = 0; g < 4; g++) step("R10", s, 1'b0, ad(g, 3), '0);
    for (int k = 0; k < NW; k++) step("R10", s, 1'b0, ad(2, k), '0);

    // Random mix with same-cycle clear/route/source collisions
    for (int c = 0; c < 3000; c++) begin
      logic [NS-1:0] rs;
      logic rw;
      for (int k = 0; k < NW; k++) rs[k*32 +: 32] = $urandom & $urandom & $urandom;
      rw = ($urandom % 3) == 0;
      step("R8", rs, rw, ad($urandom % 4, $urandom % 4),
           (($urandom % 4) == 0) ? 32'hFFFF_FFFF : $urandom);
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule